// File: doc/BRIEF.md
# Symmetric Dual-Slope PWM Timer

This block is a parameterised up/down timer (8 bits by default) that drives two pulse-width outputs with waveforms centred on the count minimum. A divider derived from the system clock produces a single-cycle count enable. The counter climbs from zero to its all-ones value and then descends again. Each channel compares the count against its own threshold. Depending on the direction of travel, a match either clears or sets that channel's output level.

Software writes a threshold on each channel's compare input at any time. The block copies that value into the channel's working threshold only at the top of the count, so a new duty cycle always starts on a period boundary. The count minimum and each channel's working threshold are reported on flag outputs. An enable per pin decides whether the waveform leaves the block.

Top module: `pcpwm_timer`

## Requirements
- R1: `presc_sel` picks the count enable rate: code 1 advances every clock, 2 every 8th, 3 every 64th, 4 every 256th, 5 every 1024th clock; codes 0, 6 and 7 halt the counter, and then every output holds its value.
- R2: The count runs 0,1,…,MAX,MAX-1,…,1,0,1,… with MAX = 2^W-1. Each extreme is held for exactly one enable interval, so one output period is 2·MAX enable intervals (510 by default), that is 2·MAX·N clocks at divide factor N.
- R3: Mode code 2 (non-inverted) drives the level low on a match while counting up and high on a match while counting down. A match at count 0 counts as up-going. With working threshold C, the pin is high for 2·C enable intervals per period.
- R4: Mode code 3 (inverted) drives the complement of mode 2, so the pin is high for 2·MAX−2·C enable intervals per period.
- R5: In mode 2, C = 0 gives a pin that is always low and C = MAX gives a pin that is always high. In mode 3 these levels swap.
- R6: In modes 2 and 3, when the count reaches MAX the level is forced to the up-going match result. The exception is a working threshold equal to MAX, which gets the down-going result. A threshold moved down from MAX therefore flips the pin at the top without any match.
- R7: The compare inputs reach the working thresholds only on the enable at which the count becomes MAX. No other event changes a working threshold.
- R8: Mode code 1 toggles the pin on every match, but only on channel A and only while `toggle_en_a` is high. In any other case, and always on channel B, mode 1 holds the pin low.
- R9: A pin whose `oe_*` input is low, or whose mode is code 0, is held low.
- R10: `ovf` is high while the count is 0, which is N clocks per period. `match_*` is high while the count equals that channel's working threshold, which is 2·N clocks per period for 0<C<MAX and N clocks for C of 0 or MAX.
- R11: After reset the count is 0 and rising, both working thresholds are 0 and both levels are low. As a result `ovf` and `match_a` read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel | input | 3 | Count-enable divider select |
| mode_a | input | 2 | Channel A output mode |
| mode_b | input | 2 | Channel B output mode |
| toggle_en_a | input | 1 | Permits toggle mode on channel A |
| cmp_a | input | W | Channel A threshold written by software |
| cmp_b | input | W | Channel B threshold written by software |
| oe_a | input | 1 | Channel A pin enable |
| oe_b | input | 1 | Channel B pin enable |
| pwm_a | output | 1 | Channel A waveform pin |
| pwm_b | output | 1 | Channel B waveform pin |
| match_a | output | 1 | Count equals channel A working threshold |
| match_b | output | 1 | Count equals channel B working threshold |
| ovf | output | 1 | Count is at zero |

## Verification
The enable that carries the count to MAX does two jobs in one cycle: it loads the new working threshold, and it applies the forced top-of-count level. The new threshold must also steer that forced level. The bench provokes this overlap by holding channel A at threshold MAX and then writing a smaller value. It judges the result by the high time measured over a whole later period, which must equal twice the new threshold. A second overlap occurs at threshold 0, where the zero flag and the match flag rise together. That case is judged by counting the high clocks of each flag per period.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    localparam int PS_W = 10;

    localparam logic [2:0] PS_STOP    = 3'd0;
    localparam logic [2:0] PS_DIV1    = 3'd1;
    localparam logic [2:0] PS_DIV8    = 3'd2;
    localparam logic [2:0] PS_DIV64   = 3'd3;
    localparam logic [2:0] PS_DIV256  = 3'd4;
    localparam logic [2:0] PS_DIV1024 = 3'd5;

    typedef enum logic [1:0] {
        CH_OFF    = 2'd0,
        CH_TOGGLE = 2'd1,
        CH_NONINV = 2'd2,
        CH_INVERT = 2'd3
    } ch_mode_e;

    // Description of the count value about to be loaded.
    typedef struct packed {
        logic dir_up;    // travelling upward into this value
        logic at_top;    // value is the all-ones maximum
        logic at_bottom; // value is zero
    } step_t;

    // {enabled, low-bit mask}: a tick fires when the masked divider bits are all ones.
    function automatic logic [PS_W:0] ps_cfg(input logic [2:0] sel);
        case (sel)
            PS_DIV1:    return {1'b1, PS_W'(0)};
            PS_DIV8:    return {1'b1, PS_W'(7)};
            PS_DIV64:   return {1'b1, PS_W'(63)};
            PS_DIV256:  return {1'b1, PS_W'(255)};
            PS_DIV1024: return {1'b1, PS_W'(1023)};
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
    import pcpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [PS_W-1:0] div_cnt;
    logic [PS_W:0]   cfg;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + 1'b1;
    end

    assign cfg  = ps_cfg(sel);
    assign tick = cfg[PS_W] && ((div_cnt & cfg[PS_W-1:0]) == cfg[PS_W-1:0]);

endmodule

// File: rtl/pcpwm_counter.sv
module pcpwm_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] value,
    output logic [W-1:0] nxt,
    output step_t        step
);

    localparam logic [W-1:0] TOP = '1;

    logic up_q;

    always_comb begin
        if (up_q) nxt = (value == TOP) ? TOP - 1'b1 : value + 1'b1;
        else      nxt = (value == '0)  ? W'(1)      : value - 1'b1;
        step.at_top    = (nxt == TOP);
        step.at_bottom = (nxt == '0);
        step.dir_up    = up_q ? (value != TOP) : (value == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            up_q  <= 1'b1;
        end else if (tick) begin
            value <= nxt;
            up_q  <= step.dir_up;
        end
    end

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel
    import pcpwm_pkg::*;
#(
    parameter int W         = 8,
    parameter bit TOGGLE_OK = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] cnt_value,
    input  logic [W-1:0] nxt_value,
    input  step_t        step,
    input  logic [W-1:0] cmp_sw,
    input  logic [1:0]   mode,
    input  logic         tog_en,
    input  logic         oe,
    output logic         pin,
    output logic         match,
    output logic [W-1:0] cmp_act
);

    localparam logic [W-1:0] TOP = '1;

    ch_mode_e     md;
    logic [W-1:0] eff;
    logic         hit, tog_ok, lvl, lvl_nxt, wave;

    assign md     = ch_mode_e'(mode);
    assign eff    = step.at_top ? cmp_sw : cmp_act;
    assign hit    = (nxt_value == eff);
    assign tog_ok = TOGGLE_OK && tog_en;

    always_comb begin
        lvl_nxt = lvl;
        case (md)
            CH_TOGGLE: if (tog_ok && hit) lvl_nxt = ~lvl;
            CH_NONINV, CH_INVERT: begin
                if (step.at_top)  lvl_nxt = (eff == TOP);
                else if (hit)     lvl_nxt = !(step.dir_up || step.at_bottom);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl     <= 1'b0;
            cmp_act <= '0;
        end else if (tick) begin
            lvl <= lvl_nxt;
            if (step.at_top) cmp_act <= cmp_sw;
        end
    end

    always_comb begin
        case (md)
            CH_NONINV: wave = lvl;
            CH_INVERT: wave = ~lvl;
            CH_TOGGLE: wave = tog_ok & lvl;
            default:   wave = 1'b0;
        endcase
    end

    assign pin   = oe & wave;
    assign match = (cnt_value == cmp_act);

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   presc_sel,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic         toggle_en_a,
    input  logic [W-1:0] cmp_a,
    input  logic [W-1:0] cmp_b,
    input  logic         oe_a,
    input  logic         oe_b,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic         match_a,
    output logic         match_b,
    output logic         ovf
);

    localparam int NCH = 2;

    logic                   tick;
    logic [W-1:0]           cnt_value, cnt_nxt;
    step_t                  step;
    logic [NCH-1:0][1:0]    ch_mode;
    logic [NCH-1:0][W-1:0]  ch_cmp, ch_act;
    logic [NCH-1:0]         ch_oe, ch_pin, ch_match;
    logic [W-1:0]           cmp_act_a, cmp_act_b;

    assign ch_mode = {mode_b, mode_a};
    assign ch_cmp  = {cmp_b, cmp_a};
    assign ch_oe   = {oe_b, oe_a};

    pcpwm_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (presc_sel),
        .tick (tick)
    );

    pcpwm_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .value (cnt_value),
        .nxt   (cnt_nxt),
        .step  (step)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pcpwm_channel #(.W(W), .TOGGLE_OK(g == 0)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .tick      (tick),
            .cnt_value (cnt_value),
            .nxt_value (cnt_nxt),
            .step      (step),
            .cmp_sw    (ch_cmp[g]),
            .mode      (ch_mode[g]),
            .tog_en    (toggle_en_a),
            .oe        (ch_oe[g]),
            .pin       (ch_pin[g]),
            .match     (ch_match[g]),
            .cmp_act   (ch_act[g])
        );
    end

    assign pwm_a     = ch_pin[0];
    assign pwm_b     = ch_pin[1];
    assign match_a   = ch_match[0];
    assign match_b   = ch_match[1];
    assign cmp_act_a = ch_act[0];
    assign cmp_act_b = ch_act[1];
    assign ovf       = (cnt_value == '0);

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic [W-1:0] cnt_value,
    input logic [W-1:0] act_a,
    input logic [W-1:0] act_b,
    input logic [1:0]   mode_b,
    input logic         pwm_b,
    input logic         oe_a,
    input logic         pwm_a
);

    localparam logic [W-1:0] TOP = '1;

    a_r2_top_turn: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_value == TOP) |=> (cnt_value == TOP - 1'b1));

    a_r2_bottom_turn: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_value == '0) |=> (cnt_value == W'(1)));

    a_r1_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_value));

    a_r7_load_a_at_top: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_a) |-> (cnt_value == TOP));

    a_r7_load_b_at_top: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_b) |-> (cnt_value == TOP));

    a_r8_b_toggle_dark: assert property (@(posedge clk) disable iff (rst)
        (mode_b == 2'd1) |-> !pwm_b);

    a_r9_pin_gated: assert property (@(posedge clk) disable iff (rst)
        !oe_a |-> !pwm_a);

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .cnt_value (cnt_value),
    .act_a     (cmp_act_a),
    .act_b     (cmp_act_b),
    .mode_b    (mode_b),
    .pwm_b     (pwm_b),
    .oe_a      (oe_a),
    .pwm_a     (pwm_a)
);

// File: tb/tb_pcpwm_timer.sv
module tb_pcpwm_timer;

    localparam int BW   = 4;
    localparam int MAXV = (1 << BW) - 1;
    localparam int T    = 2 * MAXV;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    presc_sel = 3'd0;
    logic [1:0]    mode_a = 2'd2, mode_b = 2'd2;
    logic          toggle_en_a = 1'b0;
    logic [BW-1:0] cmp_a = '0, cmp_b = '0;
    logic          oe_a = 1'b1, oe_b = 1'b1;
    logic          pwm_a, pwm_b, match_a, match_b, ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pcpwm_timer #(.W(BW)) dut (
        .clk(clk), .rst(rst), .presc_sel(presc_sel),
        .mode_a(mode_a), .mode_b(mode_b), .toggle_en_a(toggle_en_a),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .oe_a(oe_a), .oe_b(oe_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .match_a(match_a), .match_b(match_b),
        .ovf(ovf)
    );

    typedef struct {
        string tag;
        int    skip;
        int    period;
        int    hi_a;
        int    hi_b;
        int    edges_a;
        int    match_a;
        int    ovf_n;
    } exp_t;

    exp_t q[$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: measures one full period between rising edges of ovf.
    int acc_per = 0, acc_ha = 0, acc_hb = 0, acc_ed = 0, acc_ma = 0, acc_ov = 0;
    logic ovf_prev = 1'b1, pa_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            acc_per = 0; acc_ha = 0; acc_hb = 0; acc_ed = 0; acc_ma = 0; acc_ov = 0;
            ovf_prev = 1'b1; pa_prev = 1'b0;
        end else begin
            if (ovf && !ovf_prev && q.size() > 0) begin
                exp_t it;
                it = q[0];
                if (it.skip > 0) begin
                    it.skip--;
                    q[0] = it;
                end else begin
                    chk(it.tag, "period clocks", acc_per, it.period);
                    if (it.hi_a >= 0)    chk(it.tag, "pwm_a high clocks", acc_ha, it.hi_a);
                    chk(it.tag, "pwm_b high clocks", acc_hb, it.hi_b);
                    if (it.edges_a >= 0) chk(it.tag, "pwm_a edges", acc_ed, it.edges_a);
                    chk(it.tag, "R10 match_a high clocks", acc_ma, it.match_a);
                    chk(it.tag, "R10 ovf high clocks", acc_ov, it.ovf_n);
                    void'(q.pop_front());
                end
            end
            if (ovf && !ovf_prev) begin
                acc_per = 0; acc_ha = 0; acc_hb = 0; acc_ed = 0; acc_ma = 0; acc_ov = 0;
            end
            acc_per++;
            acc_ha += int'(pwm_a);
            acc_hb += int'(pwm_b);
            acc_ed += int'(pwm_a != pa_prev);
            acc_ma += int'(match_a);
            acc_ov += int'(ovf);
            ovf_prev = ovf;
            pa_prev  = pwm_a;
        end
    end

    // Driver: waits for a period start, applies the setting, queues the expectation.
    task automatic apply(input string tag, input int ps, input int ma, input int mb,
                         input int ca, input int cb, input bit ten, input bit oa, input bit ob,
                         input int per, input int ha, input int hb, input int ed,
                         input int mt, input int ov);
        logic prev;
        exp_t it;
        @(negedge clk);
        prev = ovf;
        while (1) begin
            @(negedge clk);
            if (ovf && !prev) break;
            prev = ovf;
        end
        #1;
        presc_sel   = 3'(ps);
        mode_a      = 2'(ma);
        mode_b      = 2'(mb);
        cmp_a       = BW'(ca);
        cmp_b       = BW'(cb);
        toggle_en_a = ten;
        oe_a        = oa;
        oe_b        = ob;
        it.tag = tag; it.skip = 1; it.period = per; it.hi_a = ha; it.hi_b = hb;
        it.edges_a = ed; it.match_a = mt; it.ovf_n = ov;
        q.push_back(it);
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic check_halt(input string tag, input int ps);
        logic [4:0] snap;
        int diff;
        presc_sel = 3'(ps);
        repeat (5) @(negedge clk);
        snap = {pwm_a, pwm_b, match_a, match_b, ovf};
        diff = 0;
        repeat (2000) begin
            @(negedge clk);
            if ({pwm_a, pwm_b, match_a, match_b, ovf} != snap) diff++;
        end
        chk(tag, "output changes while halted", diff, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "ovf after reset", int'(ovf), 1);
        chk("R11", "pwm_a after reset", int'(pwm_a), 0);
        chk("R11", "pwm_b after reset", int'(pwm_b), 0);
        chk("R11", "match_a after reset", int'(match_a), 1);

        presc_sel = 3'd1;

        // R3 R4 at divide 1: A non-inverted C=5, B inverted C=6
        apply("R2 R3 R4", 1, 2, 3, 5, 6, 0, 1, 1, T, 10, T - 12, 2, 2, 1);
        // R5 extremes, non-inverted
        apply("R5 noninv", 1, 2, 2, 0, MAXV, 0, 1, 1, T, 0, T, 0, 1, 1);
        // R5 extremes, inverted
        apply("R5 inv", 1, 3, 3, 0, MAXV, 0, 1, 1, T, T, 0, 0, 1, 1);
        // R6 R7: threshold at MAX, then moved down
        apply("R6 at MAX", 1, 2, 2, MAXV, 0, 0, 1, 1, T, T, 0, 0, 1, 1);
        apply("R6 R7 update", 1, 2, 2, 4, 0, 0, 1, 1, T, 8, 0, 2, 2, 1);
        // R8 toggle allowed on A, dark on B
        apply("R8 toggle", 1, 1, 1, 7, 7, 1, 1, 1, T, -1, 0, 2, 2, 1);
        apply("R8 no enable", 1, 1, 1, 7, 7, 0, 1, 1, T, 0, 0, 0, 2, 1);
        // R9 pin gating and disconnected mode
        apply("R9", 1, 2, 0, MAXV, MAXV, 0, 0, 1, T, 0, 0, 0, 1, 1);
        // R1 divide 8 with other thresholds
        apply("R1 R3 R4 div8", 2, 2, 3, 1, 14, 0, 1, 1, T * 8, 16, 16, 2, 16, 8);

        // R1 sweep over all divide factors
        apply("R1 div1",    1, 2, 3, 5, 6, 0, 1, 1, T,        10,        18,        2, 2,        1);
        apply("R1 div8",    2, 2, 3, 5, 6, 0, 1, 1, T * 8,    10 * 8,    18 * 8,    2, 2 * 8,    8);
        apply("R1 div64",   3, 2, 3, 5, 6, 0, 1, 1, T * 64,   10 * 64,   18 * 64,   2, 2 * 64,   64);
        apply("R1 div256",  4, 2, 3, 5, 6, 0, 1, 1, T * 256,  10 * 256,  18 * 256,  2, 2 * 256,  256);
        apply("R1 div1024", 5, 2, 3, 5, 6, 0, 1, 1, T * 1024, 10 * 1024, 18 * 1024, 2, 2 * 1024, 1024);

        // R1 halt codes
        check_halt("R1 code0", 0);
        presc_sel = 3'd1;
        repeat (13) @(negedge clk);
        check_halt("R1 code6", 6);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule